// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one channel of a timer. It works against a 32-bit counter that runs outside the block. In output mode, software writes a compare value into a shadow register. That value reaches the live compare register in one of two ways: on the next clock, or on the next update event when shadow loading is enabled. The channel then drives a compare output that is high while the counter is below the effective compare value.

In fractional mode, the low four bits of the compare value are a sixteenth-step fraction, and the upper 28 bits are the whole part. Each update event starts a new counter period. Over any sixteen consecutive periods, the whole part is raised by one in as many periods as the fraction says. Those periods are picked by a bit-reversed phase, so they are spread evenly.

In input mode, a capture event latches the counter into the shadow register, and software writes are dropped. With fractional mode on, the captured value has its low four bits cleared.

Software writes arrive as a valid/ready stream. The block never applies back-pressure: `wr_ready` is held high out of reset. A word is accepted on every clock where `wr_valid` is high. In input mode the accepted word is discarded. Holding `wr_valid` high for several clocks repeats the write.

Top module: `cc_channel`

## Requirements
- R1: After reset, `reg_value` is 0 and `cmp_out` is 0, and the fractional phase is 0.
- R2: In output mode with `shadow_en` low, an accepted write is visible on `reg_value` after the next clock edge. It also becomes the live compare value at that same edge.
- R3: In output mode with `shadow_en` high, an accepted write changes only `reg_value`. The live compare value keeps its old contents until a clock edge with `update_evt` high copies the shadow value into it.
- R4: `wr_ready` is 1 in every cycle after reset.
- R5: `cmp_out` is registered. After each clock edge it equals (counter < effective compare), using the values present before that edge. The comparison is unsigned.
- R6: With `frac_en` low, the effective compare value is the full 32-bit live compare value.
- R7: With `frac_en` high, the effective compare value is live[31:4] + e, where e = 1 when live[3:0] > bitrev4(phase) and e = 0 otherwise. The phase is a 4-bit count of `update_evt` edges since reset, wrapping at 16. bitrev4 swaps bit 0 with bit 3 and bit 1 with bit 2. Over 16 consecutive phases, e is 1 exactly live[3:0] times.
- R8: In input mode, a clock edge with `capture_evt` high loads `counter` into the shadow register, which is seen on `reg_value`.
- R9: In input mode, accepted writes leave `reg_value` and the live compare value unchanged.
- R10: In input mode with `frac_en` high, a captured value has bits 3:0 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| input_mode | input | 1 | 1 selects capture, 0 selects compare |
| shadow_en | input | 1 | 1 routes writes through the shadow register until an update event |
| frac_en | input | 1 | 1 enables the fractional compare/capture layout |
| wr_valid | input | 1 | Write word present |
| wr_ready | output | 1 | Write accepted (always 1 out of reset) |
| wr_data | input | 32 | Write word |
| update_evt | input | 1 | Update event: period boundary and shadow transfer |
| capture_evt | input | 1 | Capture strobe |
| counter | input | 32 | External free-running counter |
| reg_value | output | 32 | Shadow/capture register contents |
| cmp_out | output | 1 | Compare output |

## Verification
The assertions assume that the mode pins (`input_mode`, `frac_en`, `shadow_en`) change only between operations. They also assume that `update_evt` marks counter periods, since it alone advances the fractional phase. The stimulus changes mode pins only on clocks with no capture or update strobe. It pulses `update_evt` for one clock per period. It holds the counter steady around each compare so that the registered output can be predicted one edge later.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int unsigned CC_DATA_W = 32;
  localparam int unsigned CC_FRAC_W = 4;

  typedef enum logic {
    CC_MODE_COMPARE = 1'b0,
    CC_MODE_CAPTURE = 1'b1
  } cc_mode_e;
endpackage

// File: rtl/cc_regs.sv
module cc_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cc_pkg::cc_mode_e  mode,
  input  logic              shadow_en,
  input  logic              frac_en,
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              update_evt,
  input  logic              capture_evt,
  input  logic [DATA_W-1:0] counter,
  output logic [DATA_W-1:0] shadow_q,
  output logic [DATA_W-1:0] live_q
);
  import cc_pkg::*;

  logic [DATA_W-1:0] cap_val;
  logic              out_mode;

  assign out_mode = (mode == CC_MODE_COMPARE);
  assign cap_val  = frac_en ? {counter[DATA_W-1:FRAC_W], {FRAC_W{1'b0}}} : counter;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (!out_mode) begin
      if (capture_evt) shadow_q <= cap_val;
    end else if (wr_fire) begin
      shadow_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (out_mode) begin
      if (!shadow_en && wr_fire)      live_q <= wr_data;
      else if (shadow_en && update_evt) live_q <= shadow_q;
    end
  end

  // R2
  direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode && !shadow_en && wr_fire) |=> (live_q == $past(wr_data)));

  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_en && !update_evt) |=> $stable(live_q));

  // R9
  input_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_mode && wr_fire && !capture_evt) |=> ($stable(shadow_q) && $stable(live_q)));

  // R10
  frac_capture_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_mode && capture_evt && frac_en) |=> (shadow_q[FRAC_W-1:0] == '0));
endmodule

// File: rtl/cc_dither.sv
module cc_dither #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frac_en,
  input  logic              update_evt,
  input  logic [DATA_W-1:0] live,
  output logic [DATA_W-1:0] eff
);
  localparam int unsigned INT_W = DATA_W - FRAC_W;

  logic [FRAC_W-1:0] phase_q;
  logic [FRAC_W-1:0] phase_rev;
  logic              extra;
  logic [DATA_W-1:0] whole;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase_q <= '0;
    else if (update_evt) phase_q <= phase_q + 1'b1;
  end

  for (genvar gi = 0; gi < FRAC_W; gi++) begin : g_rev
    assign phase_rev[gi] = phase_q[FRAC_W-1-gi];
  end

  assign extra = (live[FRAC_W-1:0] > phase_rev);
  assign whole = {{FRAC_W{1'b0}}, live[DATA_W-1:FRAC_W]};
  assign eff   = frac_en ? (whole + {{(DATA_W-1){1'b0}}, extra}) : live;

  // R7
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_evt |=> (phase_q == $past(phase_q) + 1'b1));

  // R7
  frac_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frac_en |-> (eff[DATA_W-1:INT_W+1] == '0));
endmodule

// File: rtl/cc_compare.sv
module cc_compare #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] counter,
  input  logic [DATA_W-1:0] eff,
  output logic              cmp_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_out <= 1'b0;
    else        cmp_out <= (counter < eff);
  end

  // R5
  zero_cmp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff == '0) |=> !cmp_out);

  // R5
  top_count_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (counter == {DATA_W{1'b1}}) |=> !cmp_out);
endmodule

// File: rtl/cc_channel.sv
module cc_channel #(
  parameter int unsigned DATA_W = cc_pkg::CC_DATA_W,
  parameter int unsigned FRAC_W = cc_pkg::CC_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              input_mode,
  input  logic              shadow_en,
  input  logic              frac_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              update_evt,
  input  logic              capture_evt,
  input  logic [DATA_W-1:0] counter,
  output logic [DATA_W-1:0] reg_value,
  output logic              cmp_out
);
  import cc_pkg::*;

  cc_mode_e          mode;
  logic              wr_fire;
  logic [DATA_W-1:0] live;
  logic [DATA_W-1:0] eff;

  assign mode     = input_mode ? CC_MODE_CAPTURE : CC_MODE_COMPARE;
  assign wr_ready = rst_n;
  assign wr_fire  = wr_valid && wr_ready;

  cc_regs #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .mode(mode), .shadow_en(shadow_en),
    .frac_en(frac_en), .wr_fire(wr_fire), .wr_data(wr_data),
    .update_evt(update_evt), .capture_evt(capture_evt), .counter(counter),
    .shadow_q(reg_value), .live_q(live)
  );

  cc_dither #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_dither (
    .clk(clk), .rst_n(rst_n), .frac_en(frac_en), .update_evt(update_evt),
    .live(live), .eff(eff)
  );

  cc_compare #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .counter(counter), .eff(eff), .cmp_out(cmp_out)
  );

  // R4
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);
endmodule

// File: tb/sim_cc_channel.sv
`timescale 1ns/1ps
module sim_cc_channel;
  typedef struct {
    string       tag;
    logic        chk_cmp;
    logic        exp_cmp;
    logic        chk_reg;
    logic [31:0] exp_reg;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        input_mode = 1'b0, shadow_en = 1'b0, frac_en = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic        update_evt = 1'b0, capture_evt = 1'b0;
  logic [31:0] counter = '0;
  logic [31:0] reg_value;
  logic        cmp_out;

  int checks = 0, failures = 0, phase = 0, highs = 0;
  bit done = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  cc_channel u0 (
    .clk(clk), .rst_n(rst_n), .input_mode(input_mode), .shadow_en(shadow_en),
    .frac_en(frac_en), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .update_evt(update_evt), .capture_evt(capture_evt), .counter(counter),
    .reg_value(reg_value), .cmp_out(cmp_out)
  );

  function automatic logic extra_for(input logic [3:0] frac, input int ph);
    logic [3:0] p, r;
    p = ph[3:0];
    r = {p[0], p[1], p[2], p[3]};
    return frac > r;
  endfunction

  task automatic expect_cmp(input string tag, input logic v);
    exp_t e;
    e.tag = tag; e.chk_cmp = 1; e.exp_cmp = v; e.chk_reg = 0; e.exp_reg = '0;
    q.push_back(e);
  endtask

  task automatic expect_reg(input string tag, input logic [31:0] v);
    exp_t e;
    e.tag = tag; e.chk_cmp = 0; e.exp_cmp = 0; e.chk_reg = 1; e.exp_reg = v;
    q.push_back(e);
  endtask

  task automatic step();
    @(negedge clk);
    wr_valid = 0; update_evt = 0; capture_evt = 0;
  endtask

  // monitor: compares after each rising edge
  always @(posedge clk) begin
    #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.chk_cmp) begin
        checks++;
        if (cmp_out !== e.exp_cmp) begin
          failures++;
          $display("FAIL %s cmp_out actual=%0b expected=%0b", e.tag, cmp_out, e.exp_cmp);
        end
      end
      if (e.chk_reg) begin
        checks++;
        if (reg_value !== e.exp_reg) begin
          failures++;
          $display("FAIL %s reg_value actual=%h expected=%h", e.tag, reg_value, e.exp_reg);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    step(); expect_reg("R1", 32'h0); expect_cmp("R1", 1'b0);
    step();
    checks++;
    if (wr_ready !== 1'b1) begin
      failures++; $display("FAIL R4 wr_ready actual=%0b expected=1", wr_ready);
    end

    // R2/R6 direct load, full width compare
    wr_valid = 1; wr_data = 32'h8000_0000; expect_reg("R2", 32'h8000_0000);
    step(); counter = 32'h7FFF_FFFF; expect_cmp("R2 R6", 1'b1);
    step(); counter = 32'h8000_0000; expect_cmp("R5 R6 equal", 1'b0);
    step(); counter = 32'hFFFF_FFFF; expect_cmp("R5 top", 1'b0);
    step(); counter = 32'h0; expect_cmp("R5 zero", 1'b1);

    // R3 shadow path
    step(); shadow_en = 1;
    step(); wr_valid = 1; wr_data = 32'h100; counter = 32'h200; expect_reg("R3", 32'h100);
    step(); counter = 32'h200; expect_cmp("R3 held", 1'b1);
    step(); counter = 32'h200; expect_cmp("R3 held", 1'b1);
    step(); update_evt = 1; phase++;
    step(); counter = 32'h200; expect_cmp("R3 after update", 1'b0);
    step(); counter = 32'hFF; expect_cmp("R3 after update", 1'b1);

    // R7 fractional spreading: whole 10, fraction 3
    step(); shadow_en = 0; frac_en = 1; wr_valid = 1; wr_data = 32'hA3; counter = 32'd10;
    step(); counter = 32'd10;
    for (int i = 0; i < 16; i++) begin
      logic x;
      x = extra_for(4'h3, phase);
      step(); counter = 32'd10; expect_cmp("R7 phase", x);
      step(); counter = 32'd10; update_evt = 1; expect_cmp("R7 phase", x);
      if (x) highs++;
      phase++;
    end
    checks++;
    if (highs != 3) begin
      failures++; $display("FAIL R7 raised periods actual=%0d expected=3", highs);
    end
    step(); counter = 32'd11; expect_cmp("R7 above", 1'b0);
    step(); counter = 32'd9;  expect_cmp("R7 below", 1'b1);

    // R6 fractional off, same live value as plain number
    step(); frac_en = 0; counter = 32'hA2;
    step(); counter = 32'hA2; expect_cmp("R6", 1'b1);
    step(); counter = 32'hA3; expect_cmp("R6", 1'b0);

    // R8 capture
    step(); input_mode = 1;
    step(); capture_evt = 1; counter = 32'h1234_5677; expect_reg("R8", 32'h1234_5677);
    // R9 writes dropped, live untouched
    step(); wr_valid = 1; wr_data = 32'hDEAD_BEEF; counter = 32'hA2; expect_reg("R9", 32'h1234_5677);
    step(); wr_valid = 1; wr_data = 32'h0; counter = 32'hA2; expect_cmp("R9 live", 1'b1);
    step(); counter = 32'hA3; expect_reg("R9", 32'h1234_5677); expect_cmp("R9 live", 1'b0);
    checks++;
    if (wr_ready !== 1'b1) begin
      failures++; $display("FAIL R4 wr_ready actual=%0b expected=1", wr_ready);
    end

    // R10 fractional capture clears low bits
    step(); frac_en = 1;
    step(); capture_evt = 1; counter = 32'hCAFE_BABF; expect_reg("R10", 32'hCAFE_BAB0);
    step(); expect_reg("R10 hold", 32'hCAFE_BAB0);
    step(); step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule